// File: doc/BRIEF.md
# Configurable Compare-Multiply-Add Filter ALU

This block is the arithmetic core that runs after the convolution engine. One fixed datapath covers max-pool, average-pool, batch-norm scale and shift, ReLU, ReLU6 and element-wise add. There is no separate unit per operator. The stages run in this order:

- a pre-multiplier on two operand ports;
- a comparator whose second operand can be chosen;
- a middle adder whose second port can be chosen;
- a back multiplier.

A configuration word travels with every operand and sets the multiplexers for that operand. Data are signed fixed point with `FRAC` fraction bits.

Operands arrive as a stream and are grouped into windows. `win_first_i` marks the first element of a window and `win_last_i` marks the last. A pointwise operation is a window of one element, with both flags set.

The middle stage keeps a running register. The comparator can use it to hold a running maximum or minimum, and the adder can use it to accumulate. On the first element of a window the running value is ignored. On the last element, the result is scaled, saturated to `DW` bits and sent out with a saturation flag. ReLU6 takes two passes: a clamp at 0, then a clamp at 6.0.

Top module: `filt_alu`

## Requirements
- R1: An operand with `in_valid_i` and `win_last_i` high at clock edge n gives `valid_o` high for one cycle after edge n+2. `valid_o` is low in every other cycle.
- R2: The pre-multiplier value P depends on `cfg_i[0]`. When `cfg_i[0]`=0, P = floor(a_i*b_i / 2^FRAC), using an arithmetic shift. When `cfg_i[0]`=1, P = a_i.
- R3: The comparator output depends on `cfg_i[2:1]`. Code 0 gives P, code 1 gives max(P, X), code 2 gives min(P, X), and code 3 behaves as code 0.
- R4: The comparator operand X depends on `cfg_i[3]`. When `cfg_i[3]`=0, X = thr_i. When `cfg_i[3]`=1, X is the running value, except on a window's first element, where X = P.
- R5: The adder's second term depends on `cfg_i[5:4]`. Code 1 gives c_i, and code 2 gives the running value (0 on a window's first element). Codes 0 and 3 give 0. The adder output M becomes the new running value.
- R6: When `cfg_i[6]`=1, the result is floor(M*k_i / 2^FRAC). When `cfg_i[6]`=0, the result is M.
- R7: The result is clamped to the signed DW-bit range. `sat_o` is high with that result exactly when clamping took place.
- R8: Cycles with `in_valid_i` low leave the running value unchanged, so a window may contain gaps.
- R9: `res_o` and `sat_o` change only with `valid_o` and hold their value otherwise. Non-last elements produce no output.
- R10: While reset is held and after it is released, `valid_o`, `res_o` and `sat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand valid |
| win_first_i | input | 1 | First element of window |
| win_last_i | input | 1 | Last element of window |
| cfg_i | input | 7 | Function select word |
| a_i | input | DW | Data operand, pre-multiplier port A |
| b_i | input | DW | Pre-multiplier port B (scale) |
| c_i | input | DW | Adder port operand (shift or addend) |
| thr_i | input | DW | Comparator threshold |
| k_i | input | DW | Back-multiplier factor (reciprocal) |
| valid_o | output | 1 | Result valid |
| res_o | output | DW | Saturated result |
| sat_o | output | 1 | Result was clamped |

## Verification
Two functions meet in one cycle in several cases. A window's last element can enter the middle stage while the previous window's result is being scaled, and the next window's first element can follow on the very next edge. The bench drives windows back to back to provoke this, and checks that the new window ignores the old running value.

A second collision comes from an average window whose accumulated sum exceeds 16 bits. It checks that the back multiplier brings the sum back into range without raising `sat_o`, while the same sum with scaling turned off must saturate.

A behavioural model in the bench predicts every cycle's `valid_o`, `res_o` and `sat_o` and compares them on each clock.

// File: rtl/filt_alu_pkg.sv
package filt_alu_pkg;

  typedef enum logic [1:0] {
    CMP_PASS = 2'd0,
    CMP_MAX  = 2'd1,
    CMP_MIN  = 2'd2,
    CMP_RSVD = 2'd3
  } cmp_fn_e;

  typedef enum logic [1:0] {
    ADD_ZERO = 2'd0,
    ADD_PORT = 2'd1,
    ADD_RUN  = 2'd2,
    ADD_RSVD = 2'd3
  } add_fn_e;

  // bit6 bm_en, [5:4] add_fn, bit3 cmp_run, [2:1] cmp_fn, bit0 pm_unit
  typedef struct packed {
    logic    bm_en;
    add_fn_e add_fn;
    logic    cmp_run;
    cmp_fn_e cmp_fn;
    logic    pm_unit;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/filt_alu_ingress.sv
module filt_alu_ingress
  import filt_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  cfg_t                 cfg_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  input  logic signed [DW-1:0] thr_i,
  input  logic signed [DW-1:0] k_i,
  output logic                 valid_o,
  output logic                 first_o,
  output logic                 last_o,
  output cfg_t                 cfg_o,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [DW-1:0] c_o,
  output logic signed [DW-1:0] thr_o,
  output logic signed [DW-1:0] k_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
      cfg_o   <= '0;
      a_o     <= '0;
      b_o     <= '0;
      c_o     <= '0;
      thr_o   <= '0;
      k_o     <= '0;
    end else begin
      valid_o <= valid_i;
      // data held across bubbles to save toggles
      if (valid_i) begin
        first_o <= first_i;
        last_o  <= last_i;
        cfg_o   <= cfg_i;
        a_o     <= a_i;
        b_o     <= b_i;
        c_o     <= c_i;
        thr_o   <= thr_i;
        k_o     <= k_i;
      end
    end
  end

endmodule

// File: rtl/filt_alu_premul.sv
module filt_alu_premul #(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int ACC_W = 32
) (
  input  logic                    unit_i,
  input  logic signed [DW-1:0]    a_i,
  input  logic signed [DW-1:0]    b_i,
  output logic signed [ACC_W-1:0] pm_o
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sh;

  always_comb begin
    prod    = PW'(a_i) * PW'(b_i);
    prod_sh = prod >>> FRAC;
    pm_o    = unit_i ? ACC_W'(a_i) : ACC_W'(prod_sh);
  end

endmodule

// File: rtl/filt_alu_mid.sv
module filt_alu_mid
  import filt_alu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  cfg_t                    cfg_i,
  input  logic signed [ACC_W-1:0] pm_i,
  input  logic signed [DW-1:0]    c_i,
  input  logic signed [DW-1:0]    thr_i,
  input  logic signed [DW-1:0]    k_i,
  output logic                    valid_o,
  output logic signed [ACC_W-1:0] mid_o,
  output logic signed [DW-1:0]    k_o,
  output logic                    bm_en_o
);

  logic signed [ACC_W-1:0] run_q;
  logic signed [ACC_W-1:0] run_eff;
  logic signed [ACC_W-1:0] cmp_b;
  logic signed [ACC_W-1:0] cmp_out;
  logic signed [ACC_W-1:0] add_b;
  logic signed [ACC_W-1:0] sum;

  always_comb begin
    run_eff = first_i ? pm_i : run_q;
    cmp_b   = cfg_i.cmp_run ? run_eff : ACC_W'(thr_i);
    unique case (cfg_i.cmp_fn)
      CMP_MAX: cmp_out = (pm_i > cmp_b) ? pm_i : cmp_b;
      CMP_MIN: cmp_out = (pm_i < cmp_b) ? pm_i : cmp_b;
      default: cmp_out = pm_i;
    endcase
    unique case (cfg_i.add_fn)
      ADD_PORT: add_b = ACC_W'(c_i);
      ADD_RUN:  add_b = first_i ? '0 : run_q;
      default:  add_b = '0;
    endcase
    sum = cmp_out + add_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      valid_o <= 1'b0;
      k_o     <= '0;
      bm_en_o <= 1'b0;
    end else begin
      valid_o <= valid_i & last_i;
      if (valid_i) begin
        run_q   <= sum;
        k_o     <= k_i;
        bm_en_o <= cfg_i.bm_en;
      end
    end
  end

  assign mid_o = run_q;

  // R8
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(run_q));

  // R3
  cmp_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.cmp_fn == CMP_MAX) |-> (cmp_out >= pm_i && cmp_out >= cmp_b));

  // R3
  cmp_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.cmp_fn == CMP_MIN) |-> (cmp_out <= pm_i && cmp_out <= cmp_b));

endmodule

// File: rtl/filt_alu_back.sv
module filt_alu_back #(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    bm_en_i,
  input  logic signed [ACC_W-1:0] mid_i,
  input  logic signed [DW-1:0]    k_i,
  output logic                    valid_o,
  output logic signed [DW-1:0]    res_o,
  output logic                    sat_o
);

  localparam int PW = ACC_W + DW;
  localparam logic signed [PW-1:0] MAX_V = PW'(2 ** (DW - 1) - 1);
  localparam logic signed [PW-1:0] MIN_V = ~MAX_V;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [DW-1:0] clamped;
  logic                 clip;

  always_comb begin
    prod   = PW'(mid_i) * PW'(k_i);
    scaled = bm_en_i ? (prod >>> FRAC) : PW'(mid_i);
    if (scaled > MAX_V) begin
      clamped = MAX_V[DW-1:0];
      clip    = 1'b1;
    end else if (scaled < MIN_V) begin
      clamped = MIN_V[DW-1:0];
      clip    = 1'b1;
    end else begin
      clamped = scaled[DW-1:0];
      clip    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= clamped;
        sat_o <= clip;
      end
    end
  end

  // R7
  sat_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (res_o == MAX_V[DW-1:0] || res_o == MIN_V[DW-1:0]));

  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(res_o) && $stable(sat_o)));

endmodule

// File: rtl/filt_alu.sv
module filt_alu
  import filt_alu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int ACC_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 win_first_i,
  input  logic                 win_last_i,
  input  logic [CFG_W-1:0]     cfg_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  input  logic signed [DW-1:0] thr_i,
  input  logic signed [DW-1:0] k_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] res_o,
  output logic                 sat_o
);

  logic                    s1_valid, s1_first, s1_last;
  cfg_t                    s1_cfg;
  logic signed [DW-1:0]    s1_a, s1_b, s1_c, s1_thr, s1_k;
  logic signed [ACC_W-1:0] s1_pm;
  logic                    s2_valid, s2_bm_en;
  logic signed [ACC_W-1:0] s2_mid;
  logic signed [DW-1:0]    s2_k;

  filt_alu_ingress #(.DW(DW)) u_ingress (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .first_i (win_first_i),
    .last_i  (win_last_i),
    .cfg_i   (cfg_t'(cfg_i)),
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .thr_i   (thr_i),
    .k_i     (k_i),
    .valid_o (s1_valid),
    .first_o (s1_first),
    .last_o  (s1_last),
    .cfg_o   (s1_cfg),
    .a_o     (s1_a),
    .b_o     (s1_b),
    .c_o     (s1_c),
    .thr_o   (s1_thr),
    .k_o     (s1_k)
  );

  filt_alu_premul #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_premul (
    .unit_i (s1_cfg.pm_unit),
    .a_i    (s1_a),
    .b_i    (s1_b),
    .pm_o   (s1_pm)
  );

  filt_alu_mid #(.DW(DW), .ACC_W(ACC_W)) u_mid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .first_i (s1_first),
    .last_i  (s1_last),
    .cfg_i   (s1_cfg),
    .pm_i    (s1_pm),
    .c_i     (s1_c),
    .thr_i   (s1_thr),
    .k_i     (s1_k),
    .valid_o (s2_valid),
    .mid_o   (s2_mid),
    .k_o     (s2_k),
    .bm_en_o (s2_bm_en)
  );

  filt_alu_back #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_back (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s2_valid),
    .bm_en_i (s2_bm_en),
    .mid_i   (s2_mid),
    .k_i     (s2_k),
    .valid_o (valid_o),
    .res_o   (res_o),
    .sat_o   (sat_o)
  );

  // R1
  out_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(in_valid_i && win_last_i, 3));

endmodule

// File: tb/filt_alu_tb.sv
module filt_alu_tb;

  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, win_first = 1'b0, win_last = 1'b0;
  logic [6:0] cfg = '0;
  logic signed [DW-1:0] a = '0, b = '0, c = '0, thr = '0, k = '0;
  logic valid_o, sat_o;
  logic signed [DW-1:0] res_o;

  always #2 clk = ~clk;

  filt_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .win_first_i(win_first),
    .win_last_i(win_last), .cfg_i(cfg), .a_i(a), .b_i(b), .c_i(c), .thr_i(thr),
    .k_i(k), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // expectation delay line, entry 2 is due at the current negedge
  bit          pv   [3];
  logic [15:0] pres [3];
  bit          psat [3];
  string       ptag [3];

  longint run_acc = 0;
  logic [15:0] last_res = '0;
  bit last_sat = 1'b0;

  function automatic logic [6:0] mk(input bit bm, input int addf, input bit run,
                                    input int cmpf, input bit unit);
    return {bm, 2'(addf), run, 2'(cmpf), unit};
  endfunction

  task automatic check_out();
    checks++;
    if (valid_o !== pv[2] || res_o !== pres[2] || sat_o !== psat[2]) begin
      errors++;
      $display("FAIL %s: valid/res/sat got %0b/%h/%0b expected %0b/%h/%0b",
               ptag[2], valid_o, res_o, sat_o, pv[2], pres[2], psat[2]);
    end
  endtask

  task automatic op(input bit v, input bit f, input bit l, input logic [6:0] cf,
                    input int ia, input int ib, input int ic, input int it, input int ik,
                    input string tag);
    longint pm, rv, cb, co, ab, mid, sc;
    bit ev;
    @(negedge clk);
    check_out();
    in_valid = v; win_first = f; win_last = l; cfg = cf;
    a = 16'(ia); b = 16'(ib); c = 16'(ic); thr = 16'(it); k = 16'(ik);
    ev = 1'b0;
    if (v) begin
      pm  = cf[0] ? longint'(ia) : ((longint'(ia) * ib) >>> 8);
      rv  = f ? pm : run_acc;
      cb  = cf[3] ? rv : longint'(it);
      case (cf[2:1])
        2'd1: co = (pm > cb) ? pm : cb;
        2'd2: co = (pm < cb) ? pm : cb;
        default: co = pm;
      endcase
      case (cf[5:4])
        2'd1: ab = ic;
        2'd2: ab = f ? 0 : run_acc;
        default: ab = 0;
      endcase
      mid = co + ab;
      run_acc = mid;
      sc = cf[6] ? ((mid * ik) >>> 8) : mid;
      if (l) begin
        ev = 1'b1;
        if (sc > 32767) begin last_res = 16'h7fff; last_sat = 1'b1; end
        else if (sc < -32768) begin last_res = 16'h8000; last_sat = 1'b1; end
        else begin last_res = 16'(sc); last_sat = 1'b0; end
      end
    end
    pv[2] = pv[1]; pres[2] = pres[1]; psat[2] = psat[1]; ptag[2] = ptag[1];
    pv[1] = pv[0]; pres[1] = pres[0]; psat[1] = psat[0]; ptag[1] = ptag[0];
    pv[0] = ev; pres[0] = last_res; psat[0] = last_sat; ptag[0] = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) op(0, 0, 0, '0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      pv[i] = 0; pres[i] = '0; psat[i] = 0; ptag[i] = "R10";
    end
    repeat (3) @(negedge clk);
    // R10 reset state while held
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0 || sat_o !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset valid/res/sat %0b/%h/%0b expected 0/0000/0", valid_o, res_o, sat_o);
    end
    rst_n = 1'b1;
    idle(3, "R10");

    // R2 R5: batch-norm 2.0*1.5 + 0.25
    op(1, 1, 1, mk(0, 1, 0, 0, 0), 16'h0200, 16'h0180, 16'h0040, 0, 0, "R2");
    // R2: negative product floors
    op(1, 1, 1, mk(0, 0, 0, 0, 0), -3, 16'h0080, 0, 0, 0, "R2");
    // R5 element add via unit pre-mult
    op(1, 1, 1, mk(0, 1, 0, 0, 1), 1000, 0, -250, 0, 0, "R5");
    // R5 reserved add code gives zero
    op(1, 1, 1, mk(0, 3, 0, 0, 1), 77, 0, 500, 0, 0, "R5");
    idle(3, "R1");

    // R3 R4: ReLU then ReLU6 second pass
    op(1, 1, 1, mk(0, 0, 0, 1, 1), -900, 0, 0, 0, 0, "R3");
    op(1, 1, 1, mk(0, 0, 0, 1, 1), 1200, 0, 0, 0, 0, "R3");
    op(1, 1, 1, mk(0, 0, 0, 2, 1), 16'h0700, 0, 0, 16'h0600, 0, "R3");
    op(1, 1, 1, mk(0, 0, 0, 2, 1), 16'h0300, 0, 0, 16'h0600, 0, "R4");
    op(1, 1, 1, mk(0, 0, 0, 3, 1), -5, 0, 0, 100, 0, "R3");
    idle(3, "R9");

    // R4 R8 R9: max-pool window of 4 with a bubble inside
    op(1, 1, 0, mk(0, 0, 1, 1, 1), 40, 0, 0, 0, 0, "R9");
    op(1, 0, 0, mk(0, 0, 1, 1, 1), 95, 0, 0, 0, 0, "R9");
    op(0, 0, 0, mk(0, 0, 1, 1, 1), 5000, 0, 0, 0, 0, "R8");
    op(1, 0, 0, mk(0, 0, 1, 1, 1), -20, 0, 0, 0, 0, "R8");
    op(1, 0, 1, mk(0, 0, 1, 1, 1), 60, 0, 0, 0, 0, "R4");
    // R4 back-to-back: new window ignores old max
    op(1, 1, 1, mk(0, 0, 1, 1, 1), -7, 0, 0, 0, 0, "R4");
    op(1, 1, 0, mk(0, 0, 1, 2, 1), 300, 0, 0, 0, 0, "R4");
    op(1, 0, 1, mk(0, 0, 1, 2, 1), 500, 0, 0, 0, 0, "R4");
    idle(3, "R1");

    // R6 R5: average of 4, sum beyond 16 bits scaled back without clamp
    for (int i = 0; i < 4; i++)
      op(1, i == 0, i == 3, mk(1, 2, 0, 0, 1), 16'h7000, 0, 0, 0, 16'h0040, "R6");
    // R7: same sum without scaling clamps high
    for (int i = 0; i < 4; i++)
      op(1, i == 0, i == 3, mk(0, 2, 0, 0, 1), 16'h7000, 0, 0, 0, 0, "R7");
    // R7 products beyond range both signs
    op(1, 1, 1, mk(0, 0, 0, 0, 0), 16'h7fff, 16'h7fff, 0, 0, 0, "R7");
    op(1, 1, 1, mk(0, 0, 0, 0, 0), -32768, 16'h7fff, 0, 0, 0, "R7");
    op(1, 1, 1, mk(1, 1, 0, 0, 1), -32768, 0, -32768, 0, 16'h0100, "R7");
    idle(3, "R1");

    // mixed random stream
    begin
      bit pl = 1'b1;
      for (int i = 0; i < 400; i++) begin
        bit v = ($urandom % 5) != 0;
        bit l = ($urandom % 3) == 0;
        logic [6:0] cf = 7'($urandom);
        if (cf[3] && cf[5:4] == 2'd2) cf[5:4] = 2'd0;
        op(v, pl, l, cf, int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), "R1");
        if (v) pl = l;
      end
    end
    idle(4, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, got hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule